// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the integer datapath of a scalar core. Each cycle it takes a first operand, a second operand that has already been resolved upstream (either a register value or a sign-extended immediate), and a four-bit operation code. It returns the destination value combinationally. It covers plain and carry-chained add and subtract, six bitwise logic forms, three shifts, and access to an auxiliary register.

A four-bit flag register holds negative, zero, overflow and carry. Arithmetic and logic operations update it on the clock edge when both `en` and `set_cc` are high. The carry-chained forms consume the stored carry, so multiword sums and differences can be built one word at a time. A side register, called Y here, is loaded with the XOR of both operands by one operation and returned as the result by another.

Top module: `int_alu`

## Requirements
- R1: Opcode 0 gives a+b and opcode 2 gives a-b, both modulo 2^32.
- R2: Opcode 1 gives a+b+C and opcode 3 gives a-b-C, where C is flags bit 0 as it stands in the register before the edge.
- R3: Opcodes 4 to 9 give a&b, a|b, a^b, ~(a^b), a&~b and a|~b, in that order.
- R4: Opcode 10 shifts a left logically, 11 shifts it right logically, and 12 shifts it right arithmetically, copying bit 31 into the vacated bits. The shift amount is b[4:0] only.
- R5: Opcode 14 with `en` high loads a^b into Y at the clock edge and returns 0. Opcode 13 returns Y. Opcode 14 with `en` low leaves Y unchanged.
- R6: Flags are laid out as bit 3 N (result bit 31), bit 2 Z (result is zero), bit 1 V, and bit 0 C. For opcodes 0 to 3 with `en` and `set_cc` high, V is signed overflow. C is the carry out for add, and for subtract it is the borrow (unsigned a < b + borrow-in).
- R7: For opcodes 4 to 9 with `en` and `set_cc` high, N and Z follow the result and V and C are cleared.
- R8: The flags do not change when `set_cc` is low, when `en` is low, or when the opcode is a shift, a Y access or 15.
- R9: A synchronous reset clears the flags and Y to zero.
- R10: Opcode 15 returns 0 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation is valid and may update state |
| set_cc | input | 1 | Request a flag update |
| op | input | 4 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, already resolved |
| result | output | 32 | Destination value (combinational) |
| flags | output | 4 | Flag register {N,Z,V,C} |

## Verification
The flag register is visible on `flags` one edge after the operation that wrote it. A wrong N, Z, V or C value therefore shows on the port in the next cycle. A wrong stored C also shows in the result of the next carry-chained add or subtract. A corrupted Y stays hidden until a read-Y operation, which then returns the bad value in the same cycle. For this reason the bench follows each Y write with a read.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         set_cc,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDX = 4'd1, OP_SUB = 4'd2, OP_SUBX = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_XNOR = 4'd7,
                         OP_ANDN = 4'd8, OP_ORN = 4'd9, OP_SLL = 4'd10, OP_SRL = 4'd11,
                         OP_SRA = 4'd12, OP_RDY = 4'd13, OP_WRY = 4'd14;

  logic [3:0]   cc_q;
  logic [W-1:0] y_q;

  wire          is_sub   = (op == OP_SUB) || (op == OP_SUBX);
  wire          use_c    = (op == OP_ADDX) || (op == OP_SUBX);
  wire          arith    = (op <= OP_SUBX);
  wire          logic_op = (op >= OP_AND) && (op <= OP_ORN);
  wire [W-1:0]  b_eff    = is_sub ? ~b : b;
  wire          cin      = is_sub ? ~(use_c & cc_q[0]) : (use_c & cc_q[0]);
  wire [W:0]    sum      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  wire [SW-1:0] sh       = b[SW-1:0];
  wire          v_ar     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  wire          c_ar     = is_sub ? ~sum[W] : sum[W];

  always_comb begin
    case (op)
      OP_ADD, OP_ADDX, OP_SUB, OP_SUBX: result = sum[W-1:0];
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_XNOR: result = ~(a ^ b);
      OP_ANDN: result = a & ~b;
      OP_ORN:  result = a | ~b;
      OP_SLL:  result = a << sh;
      OP_SRL:  result = a >> sh;
      OP_SRA:  result = $unsigned($signed(a) >>> sh);
      OP_RDY:  result = y_q;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      y_q  <= '0;
    end else begin
      if (en && set_cc && (arith || logic_op))
        cc_q <= {result[W-1], result == '0, arith & v_ar, arith & c_ar};
      if (en && op == OP_WRY)
        y_q <= a ^ b;
    end
  end

  assign flags = cc_q;

  p_reset_clears_r9: assert property (@(posedge clk) rst |=> (flags == 4'd0));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(en && set_cc && (arith || logic_op)) |=> $stable(flags));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (en && set_cc && arith) |=> (flags[2] == ($past(result) == '0)) && (flags[3] == $past(result[W-1])));

  p_logic_clears_vc_r7: assert property (@(posedge clk) disable iff (rst)
    (en && set_cc && logic_op) |=> (flags[1:0] == 2'b00));

  p_y_readback_r5: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_WRY) |=> (op != OP_RDY) || (result == ($past(a) ^ $past(b))));

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd15) |-> (result == '0));
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
  logic        clk = 0, rst = 1, en = 0, set_cc = 0;
  logic [3:0]  op = 0;
  logic [31:0] a = 0, b = 0;
  logic [31:0] result;
  logic [3:0]  flags;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  int_alu u0 (.clk(clk), .rst(rst), .en(en), .set_cc(set_cc), .op(op), .a(a), .b(b),
              .result(result), .flags(flags));

  // {op, a, b, expected result}, applied with en=0 and C=0
  localparam int NV = 19;
  localparam logic [99:0] VEC [NV] = '{
    {4'd0,  32'h00000005, 32'h00000007, 32'h0000000C},
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {4'd2,  32'h0000000A, 32'h00000003, 32'h00000007},
    {4'd2,  32'h00000003, 32'h0000000A, 32'hFFFFFFF9},
    {4'd1,  32'h00000001, 32'h00000002, 32'h00000003},
    {4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
    {4'd5,  32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0},
    {4'd6,  32'hAAAA5555, 32'hFFFF0000, 32'h55555555},
    {4'd7,  32'h12345678, 32'h12345678, 32'hFFFFFFFF},
    {4'd8,  32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00000},
    {4'd9,  32'h00000000, 32'hFFFFFF00, 32'h000000FF},
    {4'd10, 32'h00000001, 32'h0000001F, 32'h80000000},
    {4'd10, 32'h00000001, 32'h00000021, 32'h00000002},
    {4'd11, 32'h80000000, 32'h00000004, 32'h08000000},
    {4'd12, 32'h80000000, 32'h00000004, 32'hF8000000},
    {4'd12, 32'h40000000, 32'h0000001E, 32'h00000001},
    {4'd13, 32'h11111111, 32'h22222222, 32'h00000000},
    {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {4'd14, 32'h12340000, 32'h00005678, 32'h00000000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic cc, logic e);
    @(negedge clk);
    op = o; a = x; b = y; set_cc = cc; en = e;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], 1'b0, 1'b0);
      chk($sformatf("R1-table vec %0d (R1 R2 R3 R4 R5 R10)", i), result, VEC[i][31:0]);
    end
    drive(4'd13, 0, 0, 0, 0);
    chk("R5 Y unchanged after disabled write", result, 32'd0);

    drive(4'd0, 32'h7FFFFFFF, 32'h1, 1, 1); tick();
    chk("R6 add overflow flags", {28'd0, flags}, 32'hA);
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 1, 1); tick();
    chk("R6 add carry zero flags", {28'd0, flags}, 32'h5);
    drive(4'd1, 32'h0, 32'h0, 0, 1);
    chk("R2 addx uses carry", result, 32'h1);
    tick();
    chk("R8 flags held without set_cc", {28'd0, flags}, 32'h5);
    drive(4'd3, 32'h5, 32'h2, 1, 1);
    chk("R2 subx uses borrow", result, 32'h2);
    tick();
    chk("R6 subx no borrow flags", {28'd0, flags}, 32'h0);
    drive(4'd2, 32'h3, 32'hA, 1, 1); tick();
    chk("R6 sub borrow flags", {28'd0, flags}, 32'h9);
    drive(4'd3, 32'h0, 32'h0, 1, 1);
    chk("R2 subx with borrow-in", result, 32'hFFFFFFFF);
    tick();
    chk("R6 subx borrow chain flags", {28'd0, flags}, 32'h9);
    drive(4'd2, 32'h80000000, 32'h1, 1, 1); tick();
    chk("R6 sub overflow flags", {28'd0, flags}, 32'h2);
    drive(4'd2, 32'h0, 32'h80000000, 1, 1); tick();
    chk("R6 sub V and C both set", {28'd0, flags}, 32'hB);
    drive(4'd4, 32'hFFFFFFFF, 32'h0, 1, 1); tick();
    chk("R7 logic clears V C", {28'd0, flags}, 32'h4);
    drive(4'd6, 32'h80000000, 32'h0, 1, 1); tick();
    chk("R7 logic sets N", {28'd0, flags}, 32'h8);
    drive(4'd0, 32'h7FFFFFFF, 32'h1, 1, 0); tick();
    chk("R8 flags held with en low", {28'd0, flags}, 32'h8);
    drive(4'd12, 32'h00000002, 32'h1, 1, 1);
    chk("R4 sra positive", result, 32'h1);
    tick();
    chk("R8 shift ignores set_cc", {28'd0, flags}, 32'h8);
    drive(4'd15, 32'h0, 32'h0, 1, 1); tick();
    chk("R10 reserved op no flag change", {28'd0, flags}, 32'h8);

    drive(4'd14, 32'h12340000, 32'h00005678, 1, 1);
    chk("R5 write-Y result zero", result, 32'h0);
    tick();
    chk("R8 write-Y leaves flags", {28'd0, flags}, 32'h8);
    drive(4'd13, 0, 0, 0, 1);
    chk("R5 read-Y after write", result, 32'h12345678);
    drive(4'd14, 32'hFFFFFFFF, 32'h0, 0, 0); tick();
    drive(4'd13, 0, 0, 0, 1);
    chk("R5 Y kept after en-low write", result, 32'h12345678);

    @(negedge clk); rst = 1; tick();
    chk("R9 reset clears flags", {28'd0, flags}, 32'h0);
    @(negedge clk); rst = 0; op = 4'd13; #1;
    chk("R9 reset clears Y", result, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule